// File: doc/BRIEF.md
# DRAM Read/Write Burst Scheduler

This block picks the next DRAM data burst from two request queues, one holding reads and one holding writes. The queue owner presents every slot of each queue as a valid bit, a bank-ready bit and a rank number. Slot 0 is the oldest entry and higher slots are younger. When the selected entry is granted, the owner removes it from its queue. One direction register decides whether reads or writes are being served. Writes are drained in batches that start at a high occupancy mark. The batch ends only after occupancy falls below a low mark and a minimum number of writes has gone out. This hysteresis keeps the scheduler from swapping direction on every burst.

Each grant comes with a delay. The delay is the number of cycles from the grant cycle to the earliest cycle the burst may use the data bus. It adds a bus turnaround gap when the direction reverses, and a further rank-change gap when the new burst targets a different rank than the previous one. Bank precharge and activate for the first read after a write batch are assumed to be hidden under the write-to-read gap, so that gap is a single fixed term. While the direction is unchanged, an eligible entry to the previous burst's rank is preferred, so bursts continue without a rank-change bubble. The block also reports the length of the current run of same-direction bursts.

Top module: `burst_sched`

## Requirements
- R1: After reset the scheduler serves reads (`write_mode`=0), `run_len` is 0, no previous burst is recorded, and with both queues empty `gnt_valid` stays 0.
- R2: At a decision cycle in read mode, the scheduler switches to write mode when the count of valid write slots is at least HI_WM, or when no read slot is valid and at least one write slot is valid. `gnt_write` is 1 exactly when the grant is served in write mode.
- R3: At a decision cycle in write mode, the scheduler returns to read mode only when at least one read slot is valid and either no write slot is valid, or fewer than LO_WM write slots are valid and at least MIN_WR writes have been granted since write mode was entered. The count of writes granted restarts at zero on each entry into write mode.
- R4: `gnt_delay` includes T_RTW when a write follows a read, and T_WTR when a read follows a write. There is no direction term for the first burst after reset or when the direction is unchanged.
- R5: `gnt_delay` includes T_CS whenever a previous burst exists and the granted entry's rank differs from the previous burst's rank. This applies to all four read/write pairings, and the term adds to the R4 term.
- R6: A grant names only a slot of the current direction's queue whose valid and ready bits are both 1.
- R7: When a previous burst exists and the direction equals its direction, the lowest-numbered eligible slot with the previous rank wins. Otherwise, or when no such slot exists, the lowest-numbered eligible slot wins.
- R8: After a grant with delay d, the next decision cycle is d+T_BURST cycles later. No grant is made and the direction does not change in the cycles between.
- R9: `run_len` is set to 1 on a grant whose direction differs from the previous burst's direction (or on the first burst), and is incremented, saturating at its maximum, on a grant in the same direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_valid | input | N | Read slot holds a request (slot 0 oldest) |
| rd_ready | input | N | Read slot's bank can accept the burst |
| rd_rank | input | N x RANK_W | Rank addressed by each read slot |
| wr_valid | input | N | Write slot holds a request (slot 0 oldest) |
| wr_ready | input | N | Write slot's bank can accept the burst |
| wr_rank | input | N x RANK_W | Rank addressed by each write slot |
| gnt_valid | output | 1 | A slot is granted this cycle |
| gnt_write | output | 1 | Granted slot is from the write queue |
| gnt_idx | output | clog2(N) | Granted slot number |
| gnt_delay | output | DLY_W | Cycles from grant to earliest bus issue |
| write_mode | output | 1 | Direction being served this cycle (1 = writes) |
| run_len | output | RUN_W | Bursts granted since the last direction change |

## Verification
Some rules are checked by the assertions on every cycle. These are eligibility of the granted slot, a high write occupancy forcing write mode, write mode persisting while occupancy is at or above the low mark, quiet cycles after each grant with a steady direction, and lower bounds on the delay at direction and rank changes. Other behaviour can only be shown by the bench's scenarios, which the bench compares against its reference model every cycle. This covers the exact slot chosen under rank preference and age order, exact delay sums, the minimum-writes condition on leaving a batch, and the run counter. The scenarios are read-only traffic, balanced mixes, write floods, writes with an empty read queue, and light writes that sit inside the hysteresis band.

// File: rtl/burst_sched_pkg.sv
package burst_sched_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/burst_sched_mode.sv
module burst_sched_mode #(
  parameter int CNT_W  = 4,
  parameter int HI_WM  = 6,
  parameter int LO_WM  = 2,
  parameter int MIN_WR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             decide,
  input  logic [CNT_W-1:0] rd_cnt,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_grant,
  output logic             eff_wr
);
  localparam int ISS_W = $clog2(MIN_WR + 1) > 0 ? $clog2(MIN_WR + 1) : 1;

  logic             mode_q;
  logic [ISS_W-1:0] iss_q, iss_d;
  logic             enter;

  always_comb begin
    eff_wr = mode_q;
    enter  = 1'b0;
    if (decide) begin
      if (!mode_q) begin
        if (wr_cnt >= CNT_W'(HI_WM) || (rd_cnt == '0 && wr_cnt != '0)) begin
          eff_wr = 1'b1;
          enter  = 1'b1;
        end
      end else if (rd_cnt != '0 &&
                   (wr_cnt == '0 || (wr_cnt < CNT_W'(LO_WM) && iss_q >= ISS_W'(MIN_WR)))) begin
        eff_wr = 1'b0;
      end
    end
  end

  always_comb begin
    iss_d = enter ? '0 : iss_q;
    if (wr_grant && iss_d < ISS_W'(MIN_WR)) iss_d = iss_d + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      iss_q  <= '0;
    end else if (decide) begin
      mode_q <= eff_wr;
      iss_q  <= iss_d;
    end
  end
endmodule

// File: rtl/burst_sched_pick.sv
module burst_sched_pick #(
  parameter int N      = 8,
  parameter int RANK_W = 2,
  parameter int IDX_W  = 3
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0]             ready,
  input  logic [N-1:0][RANK_W-1:0] rank,
  input  logic                     pref_en,
  input  logic [RANK_W-1:0]        pref_rank,
  output logic                     found,
  output logic [IDX_W-1:0]         idx,
  output logic [RANK_W-1:0]        rank_o
);
  logic             hit_pref;
  logic [IDX_W-1:0] idx_pref, idx_any;

  always_comb begin
    found    = 1'b0;
    hit_pref = 1'b0;
    idx_pref = '0;
    idx_any  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid[i] && ready[i]) begin
        found   = 1'b1;
        idx_any = IDX_W'(i);
        if (pref_en && rank[i] == pref_rank) begin
          hit_pref = 1'b1;
          idx_pref = IDX_W'(i);
        end
      end
    end
    idx    = hit_pref ? idx_pref : idx_any;
    rank_o = rank[idx];
  end
endmodule

// File: rtl/burst_sched_timer.sv
module burst_sched_timer #(
  parameter int RANK_W  = 2,
  parameter int T_RTW   = 4,
  parameter int T_WTR   = 6,
  parameter int T_CS    = 2,
  parameter int T_BURST = 4,
  parameter int RUN_W   = 8,
  parameter int DLY_W   = 4,
  parameter int HOLD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic              new_wr,
  input  logic [RANK_W-1:0] new_rank,
  output logic              decide,
  output logic [DLY_W-1:0]  delay,
  output logic [RUN_W-1:0]  run_len,
  output logic              last_vld,
  output logic              last_wr,
  output logic [RANK_W-1:0] last_rank
);
  logic [HOLD_W-1:0] hold_q;
  logic [RUN_W-1:0]  run_q;

  always_comb begin
    int d;
    d = 0;
    if (last_vld) begin
      if (new_wr != last_wr) d = d + (new_wr ? T_RTW : T_WTR);
      if (new_rank != last_rank) d = d + T_CS;
    end
    delay = DLY_W'(d);
  end

  assign decide  = (hold_q == '0);
  assign run_len = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      run_q     <= '0;
      last_vld  <= 1'b0;
      last_wr   <= 1'b0;
      last_rank <= '0;
    end else begin
      if (grant) begin
        hold_q    <= HOLD_W'(delay) + HOLD_W'(T_BURST - 1);
        last_vld  <= 1'b1;
        last_wr   <= new_wr;
        last_rank <= new_rank;
        if (last_vld && new_wr == last_wr) begin
          if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
        end else begin
          run_q <= RUN_W'(1);
        end
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import burst_sched_pkg::*;
#(
  parameter int N       = 8,
  parameter int RANK_W  = 2,
  parameter int HI_WM   = 6,
  parameter int LO_WM   = 2,
  parameter int MIN_WR  = 3,
  parameter int T_RTW   = 4,
  parameter int T_WTR   = 6,
  parameter int T_CS    = 2,
  parameter int T_BURST = 4,
  parameter int RUN_W   = 8,
  localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
  localparam int DLY_MAX = max2(T_RTW, T_WTR) + T_CS,
  localparam int DLY_W  = $clog2(DLY_MAX + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             rd_valid,
  input  logic [N-1:0]             rd_ready,
  input  logic [N-1:0][RANK_W-1:0] rd_rank,
  input  logic [N-1:0]             wr_valid,
  input  logic [N-1:0]             wr_ready,
  input  logic [N-1:0][RANK_W-1:0] wr_rank,
  output logic                     gnt_valid,
  output logic                     gnt_write,
  output logic [IDX_W-1:0]         gnt_idx,
  output logic [DLY_W-1:0]         gnt_delay,
  output logic                     write_mode,
  output logic [RUN_W-1:0]         run_len
);
  localparam int CNT_W  = $clog2(N + 1);
  localparam int HOLD_W = $clog2(DLY_MAX + T_BURST + 1);

  logic [1:0]       rst_sync;
  logic             rst_sync_n;
  logic [CNT_W-1:0] rd_cnt, wr_cnt;
  logic             decide, eff_wr, gnt_found;
  logic             last_vld, last_wr;
  logic [RANK_W-1:0] last_rank, gnt_rank;

  logic [1:0][N-1:0]             q_valid, q_ready;
  logic [1:0][N-1:0][RANK_W-1:0] q_rank;
  logic [1:0]                    pk_found;
  logic [1:0][IDX_W-1:0]         pk_idx;
  logic [1:0][RANK_W-1:0]        pk_rank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  always_comb begin
    rd_cnt = '0;
    wr_cnt = '0;
    for (int i = 0; i < N; i++) begin
      rd_cnt = rd_cnt + CNT_W'(rd_valid[i]);
      wr_cnt = wr_cnt + CNT_W'(wr_valid[i]);
    end
  end

  assign q_valid[DIR_RD] = rd_valid;
  assign q_ready[DIR_RD] = rd_ready;
  assign q_rank[DIR_RD]  = rd_rank;
  assign q_valid[DIR_WR] = wr_valid;
  assign q_ready[DIR_WR] = wr_ready;
  assign q_rank[DIR_WR]  = wr_rank;

  for (genvar c = 0; c < 2; c++) begin : g_pick
    burst_sched_pick #(.N(N), .RANK_W(RANK_W), .IDX_W(IDX_W)) u_pick (
      .valid    (q_valid[c]),
      .ready    (q_ready[c]),
      .rank     (q_rank[c]),
      .pref_en  (last_vld && (last_wr == (c == 1))),
      .pref_rank(last_rank),
      .found    (pk_found[c]),
      .idx      (pk_idx[c]),
      .rank_o   (pk_rank[c])
    );
  end

  burst_sched_mode #(.CNT_W(CNT_W), .HI_WM(HI_WM), .LO_WM(LO_WM), .MIN_WR(MIN_WR)) u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .decide  (decide),
    .rd_cnt  (rd_cnt),
    .wr_cnt  (wr_cnt),
    .wr_grant(gnt_valid && eff_wr),
    .eff_wr  (eff_wr)
  );

  assign gnt_found = pk_found[eff_wr];
  assign gnt_rank  = pk_rank[eff_wr];
  assign gnt_valid = decide && gnt_found;
  assign gnt_write = eff_wr;
  assign gnt_idx   = pk_idx[eff_wr];
  assign write_mode = eff_wr;

  burst_sched_timer #(
    .RANK_W(RANK_W), .T_RTW(T_RTW), .T_WTR(T_WTR), .T_CS(T_CS), .T_BURST(T_BURST),
    .RUN_W(RUN_W), .DLY_W(DLY_W), .HOLD_W(HOLD_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .grant    (gnt_valid),
    .new_wr   (eff_wr),
    .new_rank (gnt_rank),
    .decide   (decide),
    .delay    (gnt_delay),
    .run_len  (run_len),
    .last_vld (last_vld),
    .last_wr  (last_wr),
    .last_rank(last_rank)
  );
endmodule

// File: rtl/burst_sched_chk.sv
module burst_sched_chk #(
  parameter int N       = 8,
  parameter int RANK_W  = 2,
  parameter int HI_WM   = 6,
  parameter int LO_WM   = 2,
  parameter int T_RTW   = 4,
  parameter int T_CS    = 2,
  parameter int IDX_W   = 3,
  parameter int DLY_W   = 4,
  parameter int RUN_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N-1:0]             rd_valid,
  input logic [N-1:0]             rd_ready,
  input logic [N-1:0][RANK_W-1:0] rd_rank,
  input logic [N-1:0]             wr_valid,
  input logic [N-1:0]             wr_ready,
  input logic [N-1:0][RANK_W-1:0] wr_rank,
  input logic                     gnt_valid,
  input logic                     gnt_write,
  input logic [IDX_W-1:0]         gnt_idx,
  input logic [DLY_W-1:0]         gnt_delay,
  input logic                     write_mode,
  input logic [RUN_W-1:0]         run_len,
  input logic                     decide,
  input logic                     last_vld,
  input logic                     last_wr,
  input logic [RANK_W-1:0]        last_rank
);
  logic [RANK_W-1:0] sel_rank;
  assign sel_rank = gnt_write ? wr_rank[gnt_idx] : rd_rank[gnt_idx];

  AST_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_write ? (wr_valid[gnt_idx] && wr_ready[gnt_idx])
                             : (rd_valid[gnt_idx] && rd_ready[gnt_idx]))); // R6
  AST_HI_MARK_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && $countones(wr_valid) >= HI_WM) |-> write_mode); // R2
  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(write_mode) && $countones(wr_valid) >= LO_WM) |-> write_mode); // R3
  AST_GNT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> !gnt_valid); // R8
  AST_MODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |-> (write_mode == $past(write_mode))); // R8
  AST_RTW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && last_vld && gnt_write && !last_wr) |-> (gnt_delay >= DLY_W'(T_RTW))); // R4
  AST_RANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && last_vld && sel_rank != last_rank) |-> (gnt_delay >= DLY_W'(T_CS))); // R5
  AST_RUN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> (run_len != '0)); // R9
endmodule

bind burst_sched burst_sched_chk #(
  .N(N), .RANK_W(RANK_W), .HI_WM(HI_WM), .LO_WM(LO_WM), .T_RTW(T_RTW), .T_CS(T_CS),
  .IDX_W(IDX_W), .DLY_W(DLY_W), .RUN_W(RUN_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_rank(rd_rank),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_rank(wr_rank),
  .gnt_valid(gnt_valid), .gnt_write(gnt_write), .gnt_idx(gnt_idx), .gnt_delay(gnt_delay),
  .write_mode(write_mode), .run_len(run_len), .decide(decide),
  .last_vld(last_vld), .last_wr(last_wr), .last_rank(last_rank)
);

// File: tb/burst_sched_tb_top.sv
module burst_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8, RANK_W = 2, HI_WM = 6, LO_WM = 2, MIN_WR = 3;
  localparam int T_RTW = 4, T_WTR = 6, T_CS = 2, T_BURST = 4, RUN_MAX = 255;
  localparam int IDX_W = 3, DLY_W = 4;

  logic clk, rst_n;
  logic [N-1:0] rd_valid, rd_ready, wr_valid, wr_ready;
  logic [N-1:0][RANK_W-1:0] rd_rank, wr_rank;
  logic gnt_valid, gnt_write, write_mode;
  logic [IDX_W-1:0] gnt_idx;
  logic [DLY_W-1:0] gnt_delay;
  logic [7:0] run_len;

  burst_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_rank(rd_rank),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_rank(wr_rank),
    .gnt_valid(gnt_valid), .gnt_write(gnt_write), .gnt_idx(gnt_idx),
    .gnt_delay(gnt_delay), .write_mode(write_mode), .run_len(run_len)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0;

  // bench queues: slot 0 oldest, kept compact
  int rq_n = 0, wq_n = 0;
  int rq_rank[N], wq_rank[N];

  // reference model state
  int m_wr, m_iss, m_lastv, m_lastwr, m_lastrank, m_hold, m_run;
  int rm_v = 0, rm_wr = 0, rm_idx = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic drive(input int rdy_p);
    rd_valid = '0; wr_valid = '0; rd_ready = '0; wr_ready = '0; rd_rank = '0; wr_rank = '0;
    for (int i = 0; i < rq_n; i++) begin
      rd_valid[i] = 1'b1;
      rd_ready[i] = ($urandom_range(99) < rdy_p);
      rd_rank[i]  = RANK_W'(rq_rank[i]);
    end
    for (int i = 0; i < wq_n; i++) begin
      wr_valid[i] = 1'b1;
      wr_ready[i] = ($urandom_range(99) < rdy_p);
      wr_rank[i]  = RANK_W'(wq_rank[i]);
    end
  endtask

  function automatic int pick_rank(input int rmode);
    if (rmode == 0) return 0;
    if (rmode == 1) return $urandom_range(3);
    return $urandom_range(1) * 2;
  endfunction

  task automatic step(input int rd_p, input int wr_p, input int rmode, input int rdy_p);
    int eff, decide, found, e_idx, e_rank, pref, dly;
    // remove the slot granted last cycle
    if (rm_v != 0) begin
      if (rm_wr != 0) begin
        for (int i = rm_idx; i < wq_n - 1; i++) wq_rank[i] = wq_rank[i+1];
        wq_n--;
      end else begin
        for (int i = rm_idx; i < rq_n - 1; i++) rq_rank[i] = rq_rank[i+1];
        rq_n--;
      end
    end
    if (rq_n < N && $urandom_range(99) < rd_p) begin rq_rank[rq_n] = pick_rank(rmode); rq_n++; end
    if (wq_n < N && $urandom_range(99) < wr_p) begin wq_rank[wq_n] = pick_rank(rmode); wq_n++; end
    drive(rdy_p);
    #1;
    // reference model
    decide = (m_hold == 0);
    eff = m_wr;
    if (decide != 0) begin
      if (m_wr == 0) begin
        if (wq_n >= HI_WM || (rq_n == 0 && wq_n > 0)) eff = 1;
      end else if (rq_n > 0 && (wq_n == 0 || (wq_n < LO_WM && m_iss >= MIN_WR))) eff = 0;
    end
    found = 0; e_idx = 0; e_rank = 0;
    pref = (m_lastv != 0 && m_lastwr == eff);
    if (decide != 0) begin
      for (int p = 1; p >= 0; p--) begin
        if (found == 0 && (p == 0 || pref != 0)) begin
          for (int i = 0; i < N; i++) begin
            int v, r, k;
            v = (eff != 0) ? int'(wr_valid[i]) : int'(rd_valid[i]);
            r = (eff != 0) ? int'(wr_ready[i]) : int'(rd_ready[i]);
            k = (eff != 0) ? int'(wr_rank[i])  : int'(rd_rank[i]);
            if (found == 0 && v != 0 && r != 0 && (p == 0 || k == m_lastrank)) begin
              found = 1; e_idx = i; e_rank = k;
            end
          end
        end
      end
    end
    dly = 0;
    if (m_lastv != 0) begin
      if (eff != m_lastwr) dly += (eff != 0) ? T_RTW : T_WTR;
      if (e_rank != m_lastrank) dly += T_CS;
    end
    chk(int'(write_mode) == eff, "R2/R3 direction", int'(write_mode), eff);
    chk(int'(gnt_valid) == found, "R6/R8 grant valid", int'(gnt_valid), found);
    chk(int'(run_len) == m_run, "R9 run length", int'(run_len), m_run);
    if (found != 0 && gnt_valid) begin
      chk(int'(gnt_write) == eff, "R2 grant direction", int'(gnt_write), eff);
      chk(int'(gnt_idx) == e_idx, "R7 slot choice", int'(gnt_idx), e_idx);
      chk(int'(gnt_delay) == dly, "R4/R5 issue delay", int'(gnt_delay), dly);
    end
    // advance model
    rm_v = found; rm_wr = eff; rm_idx = e_idx;
    if (decide != 0) begin
      if (eff != 0 && m_wr == 0) m_iss = 0;
      m_wr = eff;
    end
    if (found != 0) begin
      if (eff != 0 && m_iss < MIN_WR) m_iss++;
      if (m_lastv != 0 && m_lastwr == eff) m_run = (m_run < RUN_MAX) ? m_run + 1 : m_run;
      else m_run = 1;
      m_lastv = 1; m_lastwr = eff; m_lastrank = e_rank;
      m_hold = dly + T_BURST - 1;
    end else if (m_hold > 0) m_hold--;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(100);
    m_wr = 0; m_iss = 0; m_lastv = 0; m_lastwr = 0; m_lastrank = 0; m_hold = 0; m_run = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(write_mode == 1'b0, "R1 reset direction", int'(write_mode), 0);
    chk(gnt_valid == 1'b0, "R1 no grant when empty", int'(gnt_valid), 0);
    chk(run_len == '0, "R1 reset run length", int'(run_len), 0);
    repeat (500) step(40, 0, 0, 90);   // reads only, one rank
    repeat (600) step(20, 20, 1, 75);  // balanced mix, four ranks
    repeat (600) step(10, 60, 2, 75);  // write flood, two ranks
    repeat (600) step(50, 50, 1, 60);  // heavy both
    repeat (400) step(0, 30, 1, 80);   // writes with empty read queue
    repeat (600) step(30, 8, 2, 100);  // light writes inside hysteresis band
    repeat (100) step(0, 0, 0, 100);   // drain
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule